// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes as asynchronous serial characters on a single output line. The host writes a byte into a holding register. The holding register sits in front of a shift register that the host cannot reach. A byte moves from the holding register into the shift register at the first bit strobe on which the shift register has nothing left to send. The host can therefore load the next byte while the current one is still going out on the line.

Each character has the following parts, in this order:
- a low start bit;
- 7 or 8 data bits, least significant first;
- an optional even-parity bit;
- one or two high stop bits.

An outside bit-rate strobe paces every bit, so each bit lasts one strobe interval. The host can read back the holding register at any time through `hold_rdata`. A `hold_empty` flag tells the host when it may write again.

The write port is a plain register write with no back-pressure. The host keeps to a simple rule: it writes only while `hold_empty` is high. If it writes while the flag is low, the new byte replaces the waiting one, and the waiting byte is lost. Clearing `tx_enable` does three things: the line is forced high, any character in flight is dropped, and the holding register is no longer drained.

Top module: `dbtx_top`

## Requirements
- R1: While `rst_n` is low and directly after reset, `tx_line` is 1 and `hold_empty` is 1.
- R2: A cycle with `wr_en` high loads `wr_data` into the holding register. From the next cycle, `hold_rdata` shows that byte and `hold_empty` is 0.
- R3: Suppose all of the following hold at a rising clock edge: `tx_enable` is 1, `bit_tick` is 1, `hold_empty` is 0, and the shift register is idle or is on its final stop bit. At that edge the byte moves into the shift register, and `hold_empty` reads 1 afterwards.
- R4: A character is sent in this order:
  - a 0 start bit;
  - the data bits, least significant first;
  - a parity bit, only when `frame_mode[1]`=1; it makes the number of ones across data and parity even;
  - stop bits of value 1.
  `frame_mode[2]`=1 selects 8 data bits and 0 selects 7 (bit 7 is then not sent). `frame_mode[0]`=1 selects two stop bits and 0 selects one.
- R5: A byte written while the previous character is on the line starts its start bit in the slot right after the previous character's last stop bit, with no idle slot in between.
- R6: `hold_rdata` always reflects the holding register and is unaffected by transfers. After a byte moves to the shift register, `hold_rdata` still shows that byte.
- R7: While `tx_enable` is 0, the following hold:
  - `tx_line` is 1 from the next cycle on;
  - a partly sent character is dropped;
  - no transfer happens, so `hold_empty` changes only through host writes.

  When `tx_enable` returns to 1, transmission resumes with a fresh character.
- R8: `tx_line` changes only on clock edges where `bit_tick` is 1, or where `tx_enable` is 0.
- R9: A write while `hold_empty` is 0 overwrites the waiting byte. Only the newest byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmitter enable; held 0 by the host out of reset |
| frame_mode | input | 3 | [2] 8 data bits, [1] parity on, [0] two stop bits |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| hold_rdata | output | 8 | Holding register contents |
| hold_empty | output | 1 | Holding register may be written |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The assertions rely on two assumptions about the inputs:
- `bit_tick` is a single-cycle pulse.
- `frame_mode` does not change while a character is in flight, because the frame is built from it at load time and never re-read.

The stimulus keeps within both. The strobe comes from a divide-by-eight counter. The mode changes only after the scoreboard queue has drained and the line is idle. The host side writes only after seeing `hold_empty` high, except in the deliberate overwrite case, which runs with the transmitter disabled.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
  typedef struct packed {
    logic wide;      // 1: full data width, 0: one bit fewer
    logic par_en;    // even parity bit present
    logic two_stop;  // two stop bits
  } frame_mode_t;
endpackage

// File: rtl/dbtx_hold.sv
module dbtx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] hold_q,
  output logic          empty
);
  // Data has no reset: its content is undefined until first written.
  always_ff @(posedge clk) begin
    if (wr_en) hold_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     empty <= 1'b1;
    else if (wr_en) empty <= 1'b0;
    else if (take)  empty <= 1'b1;
  end

  p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!empty && hold_q == $past(wr_data)));

  p_take_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> empty);
endmodule

// File: rtl/dbtx_shifter.sv
module dbtx_shifter
  import dbtx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          bit_tick,
  input  frame_mode_t   mode,
  input  logic [DW-1:0] hold_q,
  input  logic          hold_full,
  output logic          take,
  output logic          line
);
  localparam int FW = DW + 4;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sr, frame_v;
  logic [CW-1:0] left, nd, flen;
  logic [DW-1:0] dv;
  logic          busy, last;

  // Build the framed character from the waiting byte.
  always_comb begin
    nd      = mode.wide ? CW'(DW) : CW'(DW - 1);
    dv      = hold_q;
    if (!mode.wide) dv[DW-1] = 1'b0;
    frame_v = '1;
    frame_v[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < int'(nd)) frame_v[i+1] = dv[i];
    end
    if (mode.par_en) frame_v[nd + CW'(1)] = ^dv;
    flen = nd + CW'(2) + CW'(mode.par_en) + CW'(mode.two_stop);
  end

  assign last = busy && (left == CW'(1));
  assign take = enable && hold_full && bit_tick && (!busy || last);
  assign line = busy ? sr[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      busy <= 1'b0;
      left <= '0;
      sr   <= '1;
    end else if (take) begin
      busy <= 1'b1;
      left <= flen;
      sr   <= frame_v;
    end else if (bit_tick && busy) begin
      sr   <= {1'b1, sr[FW-1:1]};
      left <= left - CW'(1);
      if (last) busy <= 1'b0;
    end
  end

  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !line);

  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> line);

  p_tick_paced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && enable) |=> $stable(line));
endmodule

// File: rtl/dbtx_top.sv
module dbtx_top
  import dbtx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_enable,
  input  logic [2:0]    frame_mode,
  input  logic          bit_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] hold_rdata,
  output logic          hold_empty,
  output logic          tx_line
);
  frame_mode_t mode;
  logic        take;

  assign mode = frame_mode_t'(frame_mode);

  dbtx_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .hold_q  (hold_rdata),
    .empty   (hold_empty)
  );

  dbtx_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (tx_enable),
    .bit_tick  (bit_tick),
    .mode      (mode),
    .hold_q    (hold_rdata),
    .hold_full (!hold_empty),
    .take      (take),
    .line      (tx_line)
  );

  p_no_drain_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !wr_en) |=> ($stable(hold_empty) && $stable(hold_rdata)));

  p_transfer_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> $stable(hold_rdata));
endmodule

// File: tb/sim_dbtx_top.sv
module sim_dbtx_top;
  typedef struct packed {
    logic [11:0] bits;
    logic [3:0]  len;
    logic        contig;
  } frame_t;

  logic       clk = 0, rst_n = 0, tx_enable = 0, bit_tick = 0, wr_en = 0;
  logic [2:0] frame_mode = 3'b100;
  logic [7:0] wr_data = 0, hold_rdata;
  logic       hold_empty, tx_line;

  int total = 0, bad = 0, cyc = 0, tcnt = 0, slot = 0, last_end = -100;
  int idx = 0, r8_viol = 0;
  logic       mon_on = 0, in_frame = 0, tick_seen = 0, prev_line = 1;
  logic [11:0] got;
  frame_t     cur;
  frame_t     expq[$];

  always #4 clk = ~clk;   // 125 MHz

  dbtx_top u0 (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .frame_mode(frame_mode),
    .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
    .hold_rdata(hold_rdata), .hold_empty(hold_empty), .tx_line(tx_line)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic frame_t mk(input logic [7:0] d, input logic [2:0] m, input logic contig);
    frame_t f;
    int n;
    logic p;
    n = m[2] ? 8 : 7;
    p = 1'b0;
    f.bits = '1;
    f.bits[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f.bits[1+i] = d[i];
      p ^= d[i];
    end
    if (m[1]) f.bits[1+n] = p;
    f.len = 4'(1 + n + int'(m[1]) + 1 + int'(m[0]));
    f.contig = contig;
    return f;
  endfunction

  // Bit strobe: one cycle in eight.
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 8;
    bit_tick = (tcnt == 7);
  end

  always @(posedge clk) tick_seen <= bit_tick;

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!tick_seen && tx_enable && tx_line !== prev_line) r8_viol++;
      prev_line = tx_line;
      if (tick_seen) begin
        slot++;
        if (!mon_on) in_frame = 0;
        else if (!in_frame) begin
          if (tx_line == 1'b0) begin
            if (expq.size() == 0) chk(0, "R4 unexpected start", 0, 1);
            else begin
              cur = expq.pop_front();
              in_frame = 1;
              idx = 1;
              got = '1;
              got[0] = 1'b0;
              if (cur.contig) chk(slot == last_end + 1, "R5 gap", slot, last_end + 1);
            end
          end
        end else begin
          got[idx] = tx_line;
          if (idx == int'(cur.len) - 1) begin
            chk(got == cur.bits, "R4 frame", {20'd0, got}, {20'd0, cur.bits});
            in_frame = 0;
            last_end = slot;
          end
          idx++;
        end
      end
    end
  end

  // Watchdog.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic write(input logic [7:0] d);
    wr_en = 1;
    wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic contig);
    while (!hold_empty) @(negedge clk);
    expq.push_back(mk(d, frame_mode, contig));
    write(d);
  endtask

  task automatic drain();
    while (expq.size() != 0 || in_frame) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    logic [2:0] modes [6];
    modes = '{3'b100, 3'b110, 3'b111, 3'b010, 3'b001, 3'b000};
    repeat (5) @(negedge clk);
    chk(tx_line == 1 && hold_empty == 1, "R1 in reset", {tx_line, hold_empty}, 2'b11);
    rst_n = 1;
    @(negedge clk);
    chk(tx_line == 1 && hold_empty == 1, "R1 after reset", {tx_line, hold_empty}, 2'b11);

    // Disabled: write is held, nothing goes out.
    write(8'h5A);
    chk(hold_empty == 0, "R2 empty cleared", hold_empty, 0);
    chk(hold_rdata == 8'h5A, "R2 readback", hold_rdata, 8'h5A);
    repeat (40) @(negedge clk);
    chk(hold_empty == 0, "R7 no transfer while disabled", hold_empty, 0);
    chk(tx_line == 1, "R7 line idle while disabled", tx_line, 1);
    write(8'hC3);
    chk(hold_rdata == 8'hC3, "R9 overwrite", hold_rdata, 8'hC3);

    // Enable: only the newest byte is sent.
    expq.push_back(mk(8'hC3, frame_mode, 0));
    mon_on = 1;
    tx_enable = 1;
    @(posedge clk iff bit_tick);
    @(negedge clk);
    chk(hold_empty == 1, "R3 transfer on strobe", hold_empty, 1);
    chk(tx_line == 0, "R3 start bit follows transfer", tx_line, 0);
    chk(hold_rdata == 8'hC3, "R6 readback after transfer", hold_rdata, 8'hC3);
    drain();

    // Back-to-back pairs in each format.
    foreach (modes[k]) begin
      frame_mode = modes[k];
      send(8'hA5 ^ 8'(k * 37), 0);
      send(8'h3C + 8'(k * 11), 1);
      drain();
    end

    // Abort in mid-character.
    frame_mode = 3'b100;
    mon_on = 0;
    write(8'hFF);
    while (tx_line) @(negedge clk);
    repeat (20) @(negedge clk);
    tx_enable = 0;
    @(negedge clk);
    chk(tx_line == 1, "R7 abort forces line high", tx_line, 1);
    repeat (30) @(negedge clk);
    chk(tx_line == 1 && hold_empty == 1, "R7 stays idle after abort", {tx_line, hold_empty}, 2'b11);
    tx_enable = 1;
    repeat (3) @(negedge clk);
    mon_on = 1;
    send(8'h81, 0);
    drain();

    chk(r8_viol == 0, "R8 line changes only on strobe", r8_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule